// File: doc/BRIEF.md
# Double-Buffered Cursor Register Bank

This block holds the configuration of a hardware cursor in two copies. Register writes from the processor land in a holding set, and the display pipeline reads only an active set. The holding values move into the active set as one group, in the cycle after a rising edge of the vertical blank input. A copy happens only when an update has been armed.

Only a write to the base-address register arms an update. A write to the control register cancels any armed update and holds the next copy back until the base address has also been written. Writing control first and base second is therefore the valid order. Writing the base address alone is enough, so the cursor shape can change without touching control.

A blank edge that arrives while a register write is on the bus does not copy. Neither does an edge that arrives while a multi-register write sequence is open. In both cases the update stays armed for the next rising edge. Each copy produces a one-cycle completion pulse that is aligned with the change on the active outputs.

Top module: `cursor_shadow_regs`

## Requirements
- R1: During and after reset, all three active outputs read zero and `upd_done` is low.
- R2: A write to a holding register does not change any active output until a copy occurs. Addresses: 0 = control, 1 = base address, 2 = position.
- R3: A copy happens only in the cycle after the clock in which `vblank` is first sampled high, following a low sample. The active outputs change in that same cycle, and `upd_done` is high for exactly that one cycle.
- R4: A base-address write, with no control write, arms an update. The next qualifying edge then copies.
- R5: A control write disarms the bank. An edge that finds a control write not yet followed by a base write does not copy. A later base write re-arms the bank.
- R6: If `wr_en` is high in the edge cycle, no copy happens. The update stays armed and completes on the next rising edge.
- R7: While a sequence is open, rising edges do not copy. A sequence opens on `seq_start` and closes on `seq_end`; in the cycle where both are high, it stays open. The update completes on the first rising edge after the sequence closes.
- R8: Base-address bit 5 is reserved and always stored as zero. Bits 31:6 (address), bit 4 (decryption request) and bits 3:0 (upper address) are stored as written.
- R9: A copy moves control, base and position together. This includes a position value that was written without arming.
- R10: Writes to addresses 3 and above change no register.
- R11: Holding `vblank` high gives no further copy, even if a base write arms the bank during the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select |
| wr_data | input | DATA_W | Write data |
| seq_start | input | 1 | Opens a write sequence |
| seq_end | input | 1 | Closes a write sequence |
| vblank | input | 1 | Vertical blank level from the timing generator |
| act_ctrl | output | DATA_W | Active control value |
| act_base | output | DATA_W | Active base-address value |
| act_pos | output | DATA_W | Active position value |
| upd_done | output | 1 | One-cycle pulse when the active set is loaded |

## Verification
The assertions check these rules on every cycle:
- The active outputs stay stable unless `upd_done` is high.
- `upd_done` never lasts two cycles and only follows a low-to-high step of `vblank`.
- No copy follows a cycle that had a write, an open sequence or a control write still waiting for its base write.
- The reserved base bit never reaches the active set.

Whether the copied values are the right ones can only be shown by the bench scenarios, which cover:
- the ordering of control and base writes;
- deferral followed by completion on a later edge;
- ignored addresses;
- a long blank with a fresh arm inside it.

// File: rtl/cursor_shadow_pkg.sv
// Package: shared constants for the double-buffered cursor register bank.
// Assumes three cursor registers, selected by a small register index.
package cursor_shadow_pkg;
    localparam int REG_COUNT = 3;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_BASE  = 1;
    localparam int IDX_POS   = 2;
    localparam int BASE_RSV_BIT = 5;
endpackage

// File: rtl/cursor_hold_bank.sv
// Module: cursor_hold_bank
// Holds the processor-written copy of every cursor register and decodes
// which register a write strikes. Assumes DATA_W > BASE_RSV_BIT.
// Unmatched addresses are dropped.
module cursor_hold_bank
    import cursor_shadow_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [REG_COUNT-1:0][DATA_W-1:0]    hold_q,
    output logic                                ctrl_hit,
    output logic                                base_hit
);
    logic [REG_COUNT-1:0] hit;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam logic [DATA_W-1:0] KEEP_MASK =
            (g == IDX_BASE) ? ~(DATA_W'(1) << BASE_RSV_BIT) : '1;

        // Decode: this register is the target of the current write.
        assign hit[g] = wr_en && (wr_addr == ADDR_W'(g));

        // Holding storage: load masked write data on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[g] <= '0;
            else if (hit[g])
                hold_q[g] <= wr_data & KEEP_MASK;
        end
    end

    assign ctrl_hit = hit[IDX_CTRL];
    assign base_hit = hit[IDX_BASE];
endmodule

// File: rtl/cursor_arm_ctrl.sv
// Module: cursor_arm_ctrl
// Tracks the arm and control-pending flags and the open write sequence.
// It detects the rising edge of vblank and issues a copy strobe when the
// edge qualifies. Assumes vblank is already synchronous to clk.
module cursor_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    input  logic wr_en,
    input  logic ctrl_hit,
    input  logic base_hit,
    input  logic seq_start,
    input  logic seq_end,
    output logic copy,
    output logic upd_done
);
    logic vb_q, armed_q, pend_q, seq_q, done_q;
    logic vb_rise, seq_busy;

    assign vb_rise  = vblank && !vb_q;
    assign seq_busy = seq_q || seq_start;
    assign copy     = vb_rise && armed_q && !pend_q && !wr_en && !seq_busy;

    // Edge history: remember the previous vblank sample.
    always_ff @(posedge clk) begin
        if (!rst_n) vb_q <= 1'b0;
        else        vb_q <= vblank;
    end

    // Arm / pending flags: control write disarms, base write arms, copy clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (ctrl_hit) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b1;
        end else if (base_hit) begin
            armed_q <= 1'b1;
            pend_q  <= 1'b0;
        end else if (copy) begin
            armed_q <= 1'b0;
        end
    end

    // Sequence window: start wins over end in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         seq_q <= 1'b0;
        else if (seq_start) seq_q <= 1'b1;
        else if (seq_end)   seq_q <= 1'b0;
    end

    // Completion pulse: aligned with the active-set load.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= copy;
    end

    assign upd_done = done_q;
endmodule

// File: rtl/cursor_active_bank.sv
// Module: cursor_active_bank
// Active copy of the cursor registers, read by the display pipeline.
// Loads every register from the holding set at once on the copy strobe.
module cursor_active_bank
    import cursor_shadow_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             copy,
    input  logic [REG_COUNT-1:0][DATA_W-1:0] hold_q,
    output logic [REG_COUNT-1:0][DATA_W-1:0] act_q
);
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_act
        // Active storage: transfer from the holding copy on a copy strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)    act_q[g] <= '0;
            else if (copy) act_q[g] <= hold_q[g];
        end
    end
endmodule

// File: rtl/cursor_shadow_regs.sv
// Module: cursor_shadow_regs (top)
// Double-buffered cursor register bank: holding set, arm control and
// active set. Assumes single-cycle register writes and a synchronous vblank.
module cursor_shadow_regs
    import cursor_shadow_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              seq_start,
    input  logic              seq_end,
    input  logic              vblank,
    output logic [DATA_W-1:0] act_ctrl,
    output logic [DATA_W-1:0] act_base,
    output logic [DATA_W-1:0] act_pos,
    output logic              upd_done
);
    logic [REG_COUNT-1:0][DATA_W-1:0] hold_q;
    logic [REG_COUNT-1:0][DATA_W-1:0] act_q;
    logic ctrl_hit, base_hit, copy;

    cursor_hold_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hold_q(hold_q), .ctrl_hit(ctrl_hit),
        .base_hit(base_hit)
    );

    cursor_arm_ctrl u_arm (
        .clk(clk), .rst_n(rst_n), .vblank(vblank), .wr_en(wr_en),
        .ctrl_hit(ctrl_hit), .base_hit(base_hit), .seq_start(seq_start),
        .seq_end(seq_end), .copy(copy), .upd_done(upd_done)
    );

    cursor_active_bank #(.DATA_W(DATA_W)) u_act (
        .clk(clk), .rst_n(rst_n), .copy(copy), .hold_q(hold_q), .act_q(act_q)
    );

    assign act_ctrl = act_q[IDX_CTRL];
    assign act_base = act_q[IDX_BASE];
    assign act_pos  = act_q[IDX_POS];
endmodule

// File: rtl/cursor_shadow_chk.sv
// Module: cursor_shadow_chk
// Property checker for cursor_shadow_regs, attached with bind.
// It rebuilds the sequence and control-pending state from the ports only.
module cursor_shadow_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              seq_start,
    input logic              seq_end,
    input logic              vblank,
    input logic [DATA_W-1:0] act_ctrl,
    input logic [DATA_W-1:0] act_base,
    input logic [DATA_W-1:0] act_pos,
    input logic              upd_done
);
    logic seq_c, pend_c;

    // Port-level sequence tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)         seq_c <= 1'b0;
        else if (seq_start) seq_c <= 1'b1;
        else if (seq_end)   seq_c <= 1'b0;
    end

    // Port-level tracker: a control write is waiting for its base write.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_c <= 1'b0;
        else if (wr_en && wr_addr == ADDR_W'(0)) pend_c <= 1'b1;
        else if (wr_en && wr_addr == ADDR_W'(1)) pend_c <= 1'b0;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> !upd_done);
    p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_done |-> ($stable(act_ctrl) && $stable(act_base) && $stable(act_pos)));
    p_edge_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> ($past(vblank) && !$past(vblank, 2)));
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);
    p_ctrl_needs_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> !$past(pend_c));
    p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> !$past(wr_en));
    p_seq_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (!$past(seq_c) && !$past(seq_start)));
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_base[5] == 1'b0);
endmodule

bind cursor_shadow_regs cursor_shadow_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .seq_start(seq_start), .seq_end(seq_end), .vblank(vblank),
    .act_ctrl(act_ctrl), .act_base(act_base), .act_pos(act_pos),
    .upd_done(upd_done)
);

// File: tb/sim_cursor_shadow_regs.sv
// Bench for cursor_shadow_regs. A behavioural reference model is updated on
// every rising clock edge and compared 5 ns later. Scenario checks follow.
module sim_cursor_shadow_regs;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          seq_start = 1'b0, seq_end = 1'b0, vblank = 1'b0;
    logic [DW-1:0] act_ctrl, act_base, act_pos;
    logic          upd_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cursor_shadow_regs #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .seq_start(seq_start), .seq_end(seq_end),
        .vblank(vblank), .act_ctrl(act_ctrl), .act_base(act_base),
        .act_pos(act_pos), .upd_done(upd_done)
    );

    // Reference model state.
    logic [DW-1:0] m_hold [3];
    logic [DW-1:0] m_act  [3];
    bit m_armed, m_pend, m_seq, m_vbq, m_done;

    always @(posedge clk) begin
        bit edge_now, cp;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_hold[i] = '0; m_act[i] = '0; end
            m_armed = 0; m_pend = 0; m_seq = 0; m_vbq = 0; m_done = 0;
        end else begin
            edge_now = vblank && !m_vbq;
            cp = edge_now && m_armed && !m_pend && !wr_en && !(m_seq || seq_start);
            m_done = cp;
            if (cp) begin
                for (int i = 0; i < 3; i++) m_act[i] = m_hold[i];
                m_armed = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    0: begin m_hold[0] = wr_data; m_pend = 1; m_armed = 0; end
                    1: begin m_hold[1] = wr_data & ~32'h20; m_pend = 0; m_armed = 1; end
                    2: m_hold[2] = wr_data;
                    default: ;
                endcase
            end
            if (seq_start)    m_seq = 1;
            else if (seq_end) m_seq = 0;
            m_vbq = vblank;
        end
    end

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison with the model, 5 ns after the rising edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk(act_ctrl, m_act[0], "R9 model act_ctrl");
            chk(act_base, m_act[1], "R2 model act_base");
            chk(act_pos,  m_act[2], "R9 model act_pos");
            chk({31'b0, upd_done}, {31'b0, m_done}, "R3 model upd_done");
        end
    end

    task automatic wr(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vb_up();
        vblank = 1'b1;
        @(negedge clk);
    endtask

    task automatic vb_down();
        vblank = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({31'b0, upd_done}, 32'h0, "R1 reset upd_done");
        chk(act_base, 32'h0, "R1 reset act_base");
        rst_n = 1'b1;
        @(negedge clk);
        chk(act_ctrl, 32'h0, "R1 after reset act_ctrl");

        // R2, R8, R9: program all three, no effect until the blank edge.
        wr(0, 32'h0000_0027);
        wr(1, 32'hABCD_E03F);
        wr(2, 32'h0064_0032);
        @(negedge clk);
        chk(act_base, 32'h0, "R2 holding only");
        vb_up();
        chk({31'b0, upd_done}, 32'h1, "R3 pulse on edge");
        chk(act_base, 32'hABCD_E01F, "R8 reserved bit cleared");
        chk(act_ctrl, 32'h0000_0027, "R9 ctrl copied");
        chk(act_pos, 32'h0064_0032, "R9 pos copied");
        @(negedge clk);
        chk({31'b0, upd_done}, 32'h0, "R3 one-cycle pulse");
        vb_down();

        // R4: base only.
        wr(1, 32'h1234_5010);
        vb_up();
        chk(act_base, 32'h1234_5010, "R4 base alone arms");
        vb_down();

        // R5: control alone does not copy, base afterwards does.
        wr(0, 32'h0000_0005);
        vb_up();
        chk(act_ctrl, 32'h0000_0027, "R5 ctrl alone held");
        vb_down();
        wr(1, 32'h0000_1000);
        vb_up();
        chk(act_ctrl, 32'h0000_0005, "R5 ctrl after base");
        vb_down();

        // R6: a write in the edge cycle defers the copy.
        wr(1, 32'h0000_2000);
        vblank = 1'b1;
        wr(2, 32'h0011_0022);
        chk(act_base, 32'h0000_1000, "R6 deferred by write");
        vb_down();
        vb_up();
        chk(act_base, 32'h0000_2000, "R6 completes next edge");
        chk(act_pos, 32'h0011_0022, "R6 pos with deferred copy");
        vb_down();

        // R7: an open sequence defers the copy.
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        wr(1, 32'h0000_3000);
        vb_up();
        chk(act_base, 32'h0000_2000, "R7 deferred by sequence");
        vb_down();
        seq_end = 1'b1; @(negedge clk); seq_end = 1'b0;
        vb_up();
        chk(act_base, 32'h0000_3000, "R7 completes after close");
        vb_down();

        // R10: addresses 3 and above are ignored.
        wr(3, 32'hFFFF_FFFF);
        wr(9, 32'hFFFF_FFFF);
        wr(1, 32'h0000_4000);
        vb_up();
        chk(act_ctrl, 32'h0000_0005, "R10 ctrl untouched");
        chk(act_pos, 32'h0011_0022, "R10 pos untouched");

        // R11: arm during a long blank, no copy until the next rise.
        wr(1, 32'h0000_5000);
        repeat (4) @(negedge clk);
        chk(act_base, 32'h0000_4000, "R11 no copy while high");
        vb_down();
        vb_up();
        chk(act_base, 32'h0000_5000, "R11 copy on next rise");
        vb_down();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule